// File: doc/BRIEF.md
# Eight-Bit Modulo Timer with Selectable Count Clock

This block is a general-purpose timer for a microcontroller subsystem. An up-counter either runs through its full range or wraps to zero after it reaches a programmed modulo value. The count clock is chosen from four sources: every bus clock, a fixed-rate enable pulse, the rising edge of an external pin, or the falling edge of that pin. The chosen source then passes through a prescaler with nine power-of-two ratios.

Software uses four byte-wide registers on a simple write strobe and combinational read port. A control register holds the wrap flag, the interrupt enable, a stop bit and a self-clearing counter-reset strobe. A configuration register holds the prescale code, the source select and a bit that decides whether counting goes on while the system sits in wait mode. The counter value can be read, and the modulo value can be read and written. The interrupt output is raised while the flag and its enable are both set.

Top module: `modulo_timer`

## Requirements
- R1: After reset the control register (address 0) reads 0x20 (stop set), the configuration register (address 1) reads 0x00, the counter (address 2) and the modulo register (address 3) read 0, and irq_o is low.
- R2: With modulo value M not zero, each count step moves the counter up by one until it holds M, and the next step returns it to 0 and sets the flag (address 0 bit 7). With M equal to zero the counter wraps from 255 to 0 and sets the flag.
- R3: While the stop bit (address 0 bit 5) is 1, the counter and the prescaler hold their values.
- R4: The flag stays set until software writes address 0 with bit 7 at 1. A wrap in the same cycle as that write leaves the flag set.
- R5: irq_o is high exactly when the flag and the interrupt enable (address 0 bit 6) are both 1.
- R6: Writing address 0 with bit 4 at 1 clears the counter and the prescaler in that write's cycle, even when a count step is due. Bit 4 always reads 0.
- R7: Any write to the modulo register (address 3) clears the counter, the prescaler and the flag.
- R8: The counter register (address 2) is read-only. Writing it has no effect on the count.
- R9: The prescale code (address 1 bits 3:0) with value n from 0 to 8 gives one count step every 2^n source ticks. Codes 9 to 15 divide by 256.
- R10: Source code 0 (address 1 bits 5:4) ticks on every bus clock. Source code 1 ticks on each bus clock in which fix_en_i is high.
- R11: Source codes 2 and 3 tick on rising and falling pin edges. The pin goes through a two-stage synchronizer, so the count changes on the third bus clock edge after the pin changes. Each pin level must last at least two bus clocks.
- R12: While wait_i is high and address 1 bit 6 is 0, counting halts. When that bit is 1, counting goes on during wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_clk_i | input | 1 | External count pin, asynchronous |
| fix_en_i | input | 1 | Fixed-rate clock enable, one bus cycle per pulse |
| wait_i | input | 1 | System is in wait mode |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for write and read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a flag-clear write landing in the same cycle as a wrap, because the counter has to sit exactly on the modulo value when the write hits. Directed sequences count bus edges from a known clear point so that the write lands there, and they also run the full 255-to-0 and divide-by-256 cases. A constrained-random phase then mixes writes, pin toggles held for at least two cycles, enable pulses and wait periods. A cycle-level reference model in the bench predicts every register read and the interrupt during that phase.

// File: rtl/modtim_pkg.sv
package modtim_pkg;

   typedef enum logic [1:0] {
      SRC_BUS       = 2'd0,
      SRC_FIXED     = 2'd1,
      SRC_PIN_RISE  = 2'd2,
      SRC_PIN_FALL  = 2'd3
   } clk_src_e;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_CFG  = 2'd1;
   localparam logic [1:0] ADDR_CNT  = 2'd2;
   localparam logic [1:0] ADDR_MOD  = 2'd3;

endpackage

// File: rtl/modtim_src_sel.sv
module modtim_src_sel #(
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  pin_i,
   input  logic                  fix_en_i,
   input  modtim_pkg::clk_src_e  src_i,
   output logic                  tick_o
);
   import modtim_pkg::*;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("modtim_src_sel: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;
   logic                   pin_s;

   assign pin_s = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
         last_q <= pin_s;
      end
   end

   always_comb begin
      case (src_i)
         SRC_BUS:      tick_o = 1'b1;
         SRC_FIXED:    tick_o = fix_en_i;
         SRC_PIN_RISE: tick_o = pin_s & ~last_q;
         SRC_PIN_FALL: tick_o = ~pin_s & last_q;
         default:      tick_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/modtim_prescaler.sv
module modtim_prescaler #(
   parameter int MAX_CODE = 8,
   parameter int CODE_W   = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   input  logic              run_i,
   input  logic              tick_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              ce_o
);
   localparam int PS_W = MAX_CODE;

   if (MAX_CODE < 1) begin : g_bad_max
      $error("modtim_prescaler: MAX_CODE must be at least 1");
   end
   if (MAX_CODE >= (1 << CODE_W)) begin : g_bad_code
      $error("modtim_prescaler: CODE_W too narrow for MAX_CODE");
   end

   logic [CODE_W-1:0] code_eff;
   logic [PS_W:0]     span;
   logic [PS_W-1:0]   last;
   logic [PS_W-1:0]   psc_q;

   always_comb begin
      code_eff = (code_i > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code_i;
      span     = (PS_W+1)'(1) << code_eff;
      last     = span[PS_W-1:0] - PS_W'(1);
   end

   assign ce_o = run_i & tick_i & (psc_q == last);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         psc_q <= '0;
      end else if (clr_i) begin
         psc_q <= '0;
      end else if (run_i && tick_i) begin
         psc_q <= (psc_q == last) ? '0 : psc_q + PS_W'(1);
      end
   end

endmodule

// File: rtl/modtim_counter.sv
module modtim_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             ce_i,
   input  logic [CNT_W-1:0] mod_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] top_val;

   assign top_val = (mod_i == '0) ? '1 : mod_i;
   assign wrap_o  = ce_i & (cnt_q == top_val);
   assign cnt_o   = cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (ce_i) begin
         cnt_q <= wrap_o ? '0 : cnt_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/modulo_timer.sv
module modulo_timer #(
   parameter int CNT_W       = 8,
   parameter int MAX_CODE    = 8,
   parameter int CODE_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             pin_clk_i,
   input  logic             fix_en_i,
   input  logic             wait_i,
   input  logic             wr_en_i,
   input  logic [1:0]       addr_i,
   input  logic [CNT_W-1:0] wdata_i,
   output logic [CNT_W-1:0] rdata_o,
   output logic             irq_o
);
   import modtim_pkg::*;

   localparam int FLAG_B = CNT_W - 1;
   localparam int IE_B   = CNT_W - 2;
   localparam int STOP_B = CNT_W - 3;
   localparam int RST_B  = CNT_W - 4;
   localparam int SRC_LO = CODE_W;
   localparam int SRC_HI = CODE_W + 1;
   localparam int WRUN_B = CODE_W + 2;

   if (CNT_W < 8) begin : g_bad_width
      $error("modulo_timer: CNT_W must be at least 8");
   end
   if (WRUN_B >= CNT_W) begin : g_bad_cfg
      $error("modulo_timer: configuration fields do not fit the data width");
   end

   logic             stop_q, ie_q, flag_q, wrun_q;
   logic [CODE_W-1:0] code_q;
   clk_src_e         src_q;
   logic [CNT_W-1:0] mod_q;
   logic [CNT_W-1:0] cnt_w;

   logic wr_ctrl, wr_cfg, wr_mod;
   logic strobe, w1c, clr_all, run;
   logic tick, ce, wrap;

   assign wr_ctrl = wr_en_i && (addr_i == ADDR_CTRL);
   assign wr_cfg  = wr_en_i && (addr_i == ADDR_CFG);
   assign wr_mod  = wr_en_i && (addr_i == ADDR_MOD);
   assign strobe  = wr_ctrl & wdata_i[RST_B];
   assign w1c     = wr_ctrl & wdata_i[FLAG_B];
   assign clr_all = strobe | wr_mod;
   assign run     = ~stop_q & ~(wait_i & ~wrun_q);

   modtim_src_sel #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_src (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pin_i    (pin_clk_i),
      .fix_en_i (fix_en_i),
      .src_i    (src_q),
      .tick_o   (tick)
   );

   modtim_prescaler #(
      .MAX_CODE (MAX_CODE),
      .CODE_W   (CODE_W)
   ) u_psc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_all),
      .run_i  (run),
      .tick_i (tick),
      .code_i (code_q),
      .ce_o   (ce)
   );

   modtim_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_all),
      .ce_i   (ce),
      .mod_i  (mod_q),
      .cnt_o  (cnt_w),
      .wrap_o (wrap)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stop_q <= 1'b1;
         ie_q   <= 1'b0;
         wrun_q <= 1'b0;
         code_q <= '0;
         src_q  <= SRC_BUS;
         mod_q  <= '0;
      end else begin
         if (wr_ctrl) begin
            ie_q   <= wdata_i[IE_B];
            stop_q <= wdata_i[STOP_B];
         end
         if (wr_cfg) begin
            code_q <= wdata_i[CODE_W-1:0];
            src_q  <= clk_src_e'(wdata_i[SRC_HI:SRC_LO]);
            wrun_q <= wdata_i[WRUN_B];
         end
         if (wr_mod) begin
            mod_q <= wdata_i;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag_q <= 1'b0;
      end else if (wrap && !clr_all) begin
         flag_q <= 1'b1;
      end else if (w1c || wr_mod) begin
         flag_q <= 1'b0;
      end
   end

   assign irq_o = flag_q & ie_q;

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         ADDR_CTRL: begin
            rdata_o[FLAG_B] = flag_q;
            rdata_o[IE_B]   = ie_q;
            rdata_o[STOP_B] = stop_q;
         end
         ADDR_CFG: begin
            rdata_o[CODE_W-1:0]   = code_q;
            rdata_o[SRC_HI:SRC_LO] = src_q;
            rdata_o[WRUN_B]       = wrun_q;
         end
         ADDR_CNT: rdata_o = cnt_w;
         default:  rdata_o = mod_q;
      endcase
   end

endmodule

// File: rtl/modulo_timer_chk.sv
module modulo_timer_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             wr_en_i,
   input logic [1:0]       addr_i,
   input logic [CNT_W-1:0] wdata_i,
   input logic [CNT_W-1:0] cnt_w,
   input logic             flag_q,
   input logic             stop_q
);
   import modtim_pkg::*;

   localparam int FLAG_B = CNT_W - 1;
   localparam int RST_B  = CNT_W - 4;

   p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(cnt_w) |-> (cnt_w == '0 || cnt_w == $past(cnt_w) + CNT_W'(1)));

   p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stop_q && !wr_en_i) |=> $stable(cnt_w));

   p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q && !(wr_en_i && addr_i == ADDR_CTRL && wdata_i[FLAG_B])
              && !(wr_en_i && addr_i == ADDR_MOD)) |=> flag_q);

   p_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == ADDR_CTRL && wdata_i[RST_B]) |=> (cnt_w == '0));

   p_modclr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == ADDR_MOD) |=> (cnt_w == '0 && !flag_q));

endmodule

bind modulo_timer modulo_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .wr_en_i (wr_en_i),
   .addr_i  (addr_i),
   .wdata_i (wdata_i),
   .cnt_w   (cnt_w),
   .flag_q  (flag_q),
   .stop_q  (stop_q)
);

// File: tb/modulo_timer_tb_top.sv
`timescale 1ns/100ps
module modulo_timer_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin = 1'b0;
   logic       fix = 1'b0;
   logic       wt = 1'b0;
   logic       we = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wd = 8'd0;
   wire  [7:0] rd;
   wire        irq;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   modulo_timer dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .pin_clk_i (pin),
      .fix_en_i  (fix),
      .wait_i    (wt),
      .wr_en_i   (we),
      .addr_i    (addr),
      .wdata_i   (wd),
      .rdata_o   (rd),
      .irq_o     (irq)
   );

   // ---------------- reference model, written from the requirements
   bit       m_s0, m_s1, m_p, m_stop, m_ie, m_wrun, m_flag;
   bit [1:0] m_src;
   bit [3:0] m_code;
   int       m_psc;
   bit [7:0] m_cnt, m_mod;

   function automatic int mdiv(bit [3:0] c);
      return (c > 4'd8) ? 256 : (1 << c);
   endfunction

   function automatic bit [7:0] mread(bit [1:0] a);
      case (a)
         2'd0:    return {m_flag, m_ie, m_stop, 5'd0};
         2'd1:    return {1'b0, m_wrun, m_src, m_code};
         2'd2:    return m_cnt;
         default: return m_mod;
      endcase
   endfunction

   always @(posedge clk) begin : model
      bit tk, act, ce, wrp, clr, w_ctrl, w_cfg, w_mod;
      int dv;
      if (!rst_n) begin
         m_s0 = 0; m_s1 = 0; m_p = 0; m_stop = 1; m_ie = 0; m_wrun = 0;
         m_flag = 0; m_src = 0; m_code = 0; m_psc = 0; m_cnt = 0; m_mod = 0;
      end else begin
         case (m_src)
            2'd0:    tk = 1'b1;
            2'd1:    tk = fix;
            2'd2:    tk = m_s1 && !m_p;
            default: tk = !m_s1 && m_p;
         endcase
         m_p = m_s1; m_s1 = m_s0; m_s0 = pin;
         dv  = mdiv(m_code);
         act = !m_stop && !(wt && !m_wrun);
         ce  = act && tk && (m_psc == dv - 1);
         wrp = ce && (m_cnt == ((m_mod == 8'd0) ? 8'hFF : m_mod));
         w_ctrl = we && addr == 2'd0;
         w_cfg  = we && addr == 2'd1;
         w_mod  = we && addr == 2'd3;
         clr = (w_ctrl && wd[4]) || w_mod;
         if (clr) begin
            m_cnt = 0; m_psc = 0;
         end else begin
            if (act && tk) m_psc = (m_psc == dv - 1) ? 0 : m_psc + 1;
            if (ce) m_cnt = wrp ? 8'd0 : m_cnt + 8'd1;
         end
         if (wrp && !clr) m_flag = 1;
         else if ((w_ctrl && wd[7]) || w_mod) m_flag = 0;
         if (w_ctrl) begin m_ie = wd[6]; m_stop = wd[5]; end
         if (w_cfg)  begin m_code = wd[3:0]; m_src = wd[5:4]; m_wrun = wd[6]; end
         if (w_mod)  m_mod = wd;
      end
   end

   // ---------------- helpers
   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      addr = a; wd = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic expect_reg(string tag, logic [1:0] a, int exp);
      addr = a;
      #0.5;
      check(tag, int'(rd), exp);
   endtask

   task automatic expect_irq(string tag, int exp);
      #0.5;
      check(tag, int'(irq), exp);
   endtask

   task automatic finish_up();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   // ---------------- stimulus
   initial begin
      int held;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      expect_reg("R1 ctrl", 2'd0, 8'h20);
      expect_reg("R1 cfg", 2'd1, 8'h00);
      expect_reg("R1 cnt", 2'd2, 0);
      expect_reg("R1 mod", 2'd3, 0);
      expect_irq("R1 irq", 0);
      idle(1);

      // R2 modulo wrap, R5 interrupt
      wr(2'd3, 8'd5);
      wr(2'd0, 8'h40);
      idle(5);
      expect_reg("R2 reach modulo", 2'd2, 5);
      expect_reg("R2 no flag before wrap", 2'd0, 8'h40);
      idle(1);
      expect_reg("R2 wrap to zero", 2'd2, 0);
      expect_reg("R2 flag on wrap", 2'd0, 8'hC0);
      expect_irq("R5 irq with enable", 1);

      // R4 write-one clear, then clear colliding with wrap
      wr(2'd0, 8'hC0);
      expect_reg("R4 cleared flag", 2'd0, 8'h40);
      expect_reg("R4 count continues", 2'd2, 1);
      expect_irq("R5 irq drops", 0);
      idle(4);
      wr(2'd0, 8'hC0);
      expect_reg("R4 wrap beats clear", 2'd0, 8'hC0);

      // R3 stop
      wr(2'd0, 8'h60);
      idle(10);
      expect_reg("R3 stop holds count", 2'd2, 1);
      expect_reg("R3 stop readback", 2'd0, 8'hE0);

      // R6 reset strobe
      wr(2'd0, 8'h50);
      expect_reg("R6 strobe clears", 2'd2, 0);
      expect_reg("R6 strobe reads zero", 2'd0, 8'hC0);
      idle(3);
      expect_reg("R6 counts after strobe", 2'd2, 3);
      wr(2'd0, 8'h50);
      expect_reg("R6 strobe beats count", 2'd2, 0);

      // R7 modulo write clears
      idle(2);
      wr(2'd3, 8'd0);
      expect_reg("R7 mod write clears count", 2'd2, 0);
      expect_reg("R7 mod write clears flag", 2'd0, 8'h40);

      // R2 free-running wrap at 255
      idle(255);
      expect_reg("R2 free-run top", 2'd2, 255);
      expect_reg("R2 no flag at top", 2'd0, 8'h40);
      idle(1);
      expect_reg("R2 free-run wrap", 2'd2, 0);
      expect_reg("R2 free-run flag", 2'd0, 8'hC0);

      // R8 counter is read-only
      wr(2'd2, 8'h33);
      expect_reg("R8 write to counter ignored", 2'd2, 1);
      expect_reg("R8 modulo untouched", 2'd3, 0);

      // R9 prescaler
      wr(2'd1, 8'h02);
      wr(2'd3, 8'd0);
      idle(7);
      expect_reg("R9 div4 first step", 2'd2, 1);
      idle(1);
      expect_reg("R9 div4 second step", 2'd2, 2);
      wr(2'd1, 8'h0C);
      wr(2'd3, 8'd0);
      idle(255);
      expect_reg("R9 code 12 before 256", 2'd2, 0);
      idle(1);
      expect_reg("R9 code 12 at 256", 2'd2, 1);

      // R10 fixed-rate enable source
      wr(2'd1, 8'h10);
      wr(2'd3, 8'd0);
      idle(5);
      expect_reg("R10 no enable no count", 2'd2, 0);
      fix = 1'b1;
      idle(3);
      fix = 1'b0;
      expect_reg("R10 counts enables", 2'd2, 3);

      // R11 pin rising edges
      wr(2'd1, 8'h20);
      wr(2'd3, 8'd0);
      pin = 1'b1;
      idle(2);
      expect_reg("R11 rise sync latency", 2'd2, 0);
      idle(1);
      expect_reg("R11 rise counted", 2'd2, 1);
      idle(3); pin = 1'b0; idle(4); pin = 1'b1; idle(4); pin = 1'b0; idle(4);
      expect_reg("R11 only rising edges", 2'd2, 2);

      // R11 pin falling edges
      wr(2'd1, 8'h30);
      wr(2'd3, 8'd0);
      pin = 1'b1;
      idle(4);
      pin = 1'b0;
      idle(2);
      expect_reg("R11 fall sync latency", 2'd2, 0);
      idle(1);
      expect_reg("R11 fall counted", 2'd2, 1);

      // R12 wait mode
      wr(2'd1, 8'h00);
      wr(2'd3, 8'd0);
      wt = 1'b1;
      idle(5);
      expect_reg("R12 halted in wait", 2'd2, 0);
      wr(2'd1, 8'h40);
      idle(4);
      expect_reg("R12 runs in wait when allowed", 2'd2, 4);
      wt = 1'b0;

      // R5 enable masks the interrupt
      wr(2'd0, 8'h00);
      wr(2'd3, 8'd2);
      idle(3);
      expect_reg("R5 flag set with enable off", 2'd0, 8'h80);
      expect_irq("R5 irq masked", 0);
      wr(2'd0, 8'h40);
      expect_irq("R5 irq after enable", 1);

      // constrained random phase against the model (R2 model comparison)
      held = 0;
      for (int i = 0; i < 4000; i++) begin
         int r;
         logic [7:0] d;
         r = int'($urandom % 16);
         d = 8'($urandom);
         we = 1'b0;
         addr = 2'($urandom);
         if (r == 0) begin
            d[5] = ($urandom % 8 == 0);
            we = 1'b1; addr = 2'd0;
         end else if (r == 1) begin
            if ($urandom % 4 != 0) d[3:0] = 4'($urandom % 3);
            we = 1'b1; addr = 2'd1;
         end else if (r == 2) begin
            if ($urandom % 2 == 0) d = 8'($urandom % 8);
            we = 1'b1; addr = 2'd3;
         end else if (r == 3) begin
            we = 1'b1; addr = 2'd2;
         end
         wd = d;
         held++;
         if (held >= 2 && ($urandom % 3 == 0)) begin
            pin = ~pin;
            held = 0;
         end
         fix = 1'($urandom);
         wt  = ($urandom % 8 == 0);
         #0.5;
         check("R2 model register read", int'(rd), int'(mread(addr)));
         check("R5 model irq", int'(irq), int'(m_flag && m_ie));
         @(negedge clk);
      end
      we = 1'b0;
      finish_up();
   end

endmodule